// File: doc/BRIEF.md
# Data-Driven Vector Multiply-Accumulate Node

This block is a processing node in a dataflow fabric. Nothing external schedules it: it acts only when both operand streams hold a valid word in the same cycle. Each operand stream carries a 16-bit signed word and an end-of-vector flag. The block multiplies each operand pair it takes in.

In accumulate mode the block sums the products of one vector and emits a single 40-bit result when the pair that carries the end-of-vector token arrives. In multiply mode it emits every product as soon as the pair is consumed. A single output register sits in front of a valid/ready result port. While that register holds a result nobody has taken, the node stops consuming operands. A sticky error flag records any pair whose two end-of-vector flags disagree.

Top module: `vmac_node`

## Requirements
- R1: A pair is consumed only in a clock cycle where a_valid_i, b_valid_i and the shared ready are all high. a_ready_o and b_ready_o always carry the same value, and that value does not depend on either valid. A word offered on only one stream is never consumed and produces no output.
- R2: The ready outputs are high exactly when the output register is empty or res_ready_i is high. While res_valid_o is high and res_ready_i is low, res_valid_o stays high and res_data_o stays unchanged.
- R3: With mode_i=1 (multiply), each consumed pair makes res_valid_o high in the next cycle. res_data_o is then the signed product a*b, sign-extended to 40 bits.
- R4: With mode_i=0 (accumulate), a consumed pair whose end-of-vector token is absent produces no output. The token is present when a_last_i or b_last_i is 1. A pair carrying the token makes res_valid_o high in the next cycle, with res_data_o equal to the signed sum of all products of the vector, that pair included.
- R5: The running sum restarts at zero after every vector result is formed. Every pair consumed in multiply mode also restarts it.
- R6: A vector of one element, with the token on its first pair, yields that pair's product as its result.
- R7: A consumed pair with a_last_i different from b_last_i sets err_o from the next cycle. err_o then stays high until reset. Such a pair still ends the vector.
- R8: After reset, res_valid_o=0, err_o=0, both ready outputs are 1 and the running sum is zero.
- R9: The running sum wraps modulo 2^40 as a two's complement value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = accumulate per vector, 1 = emit each product |
| a_valid_i | input | 1 | Operand A word present |
| a_ready_o | output | 1 | Node takes operand A this cycle if valid |
| a_data_i | input | 16 | Operand A, signed |
| a_last_i | input | 1 | Operand A end-of-vector flag |
| b_valid_i | input | 1 | Operand B word present |
| b_ready_o | output | 1 | Node takes operand B this cycle if valid |
| b_data_i | input | 16 | Operand B, signed |
| b_last_i | input | 1 | Operand B end-of-vector flag |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | 40 | Result, signed |
| err_o | output | 1 | Sticky end-of-vector mismatch flag |

## Verification
A running sum that is not cleared shows up as a wrong value in the very next vector result. A corrupted sum shows up no later than the end of the current vector. A fault in the output register or in the ready logic shows up within one cycle of backpressure: a result changes while it is held, or a pair is consumed while the output is stalled. A fault in the mismatch flag shows up one cycle after the offending pair, or as a flag that drops while the node keeps running.

// File: rtl/vmac_pkg.sv
package vmac_pkg;
  typedef enum logic {
    MODE_ACC = 1'b0,
    MODE_MUL = 1'b1
  } vmac_mode_e;
endpackage

// File: rtl/vmac_join.sv
// Firing rule: both operands present and an output slot available.
module vmac_join (
  input  logic a_valid_i,
  input  logic b_valid_i,
  input  logic a_last_i,
  input  logic b_last_i,
  input  logic slot_free_i,
  output logic ready_o,
  output logic fire_o,
  output logic eov_o,
  output logic mismatch_o
);
  assign ready_o    = slot_free_i;
  assign fire_o     = a_valid_i & b_valid_i & slot_free_i;
  assign eov_o      = a_last_i | b_last_i;
  assign mismatch_o = fire_o & (a_last_i ^ b_last_i);
endmodule

// File: rtl/vmac_mac.sv
module vmac_mac
  import vmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             eov_i,
  input  vmac_mode_e       mode_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic             emit_o,
  output logic [ACC_W-1:0] result_o
);
  localparam int PROD_W = 2 * OP_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;
  logic        [ACC_W-1:0]  acc_q;
  logic        [ACC_W-1:0]  sum;

  assign prod = $signed(a_i) * $signed(b_i);

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  assign sum = acc_q + prod_ext;  // wraps modulo 2^ACC_W

  always_comb begin
    emit_o   = 1'b0;
    result_o = sum;
    if (fire_i) begin
      if (mode_i == MODE_MUL) begin
        emit_o   = 1'b1;
        result_o = prod_ext;
      end else begin
        emit_o = eov_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (fire_i) begin
      if (mode_i == MODE_MUL || eov_i) acc_q <= '0;
      else                             acc_q <= sum;
    end
  end
endmodule

// File: rtl/vmac_out.sv
module vmac_out #(
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic [ACC_W-1:0] data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [ACC_W-1:0] data_o,
  output logic             slot_free_o
);
  assign slot_free_o = ~valid_o | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (emit_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vmac_node.sv
module vmac_node
  import vmac_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_i,
  input  logic             a_valid_i,
  output logic             a_ready_o,
  input  logic [OP_W-1:0]  a_data_i,
  input  logic             a_last_i,
  input  logic             b_valid_i,
  output logic             b_ready_o,
  input  logic [OP_W-1:0]  b_data_i,
  input  logic             b_last_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [ACC_W-1:0] res_data_o,
  output logic             err_o
);
  logic             slot_free, ready, fire, eov, mismatch, emit;
  logic [ACC_W-1:0] result;
  vmac_mode_e       mode;

  assign mode = vmac_mode_e'(mode_i);

  vmac_join u_join (
    .a_valid_i  (a_valid_i),
    .b_valid_i  (b_valid_i),
    .a_last_i   (a_last_i),
    .b_last_i   (b_last_i),
    .slot_free_i(slot_free),
    .ready_o    (ready),
    .fire_o     (fire),
    .eov_o      (eov),
    .mismatch_o (mismatch)
  );

  vmac_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .eov_i   (eov),
    .mode_i  (mode),
    .a_i     (a_data_i),
    .b_i     (b_data_i),
    .emit_o  (emit),
    .result_o(result)
  );

  vmac_out #(.ACC_W(ACC_W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .emit_i     (emit),
    .data_i     (result),
    .ready_i    (res_ready_i),
    .valid_o    (res_valid_o),
    .data_o     (res_data_o),
    .slot_free_o(slot_free)
  );

  assign a_ready_o = ready;
  assign b_ready_o = ready;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       err_o <= 1'b0;
    else if (mismatch) err_o <= 1'b1;
  end
endmodule

// File: rtl/vmac_node_chk.sv
module vmac_node_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_i,
  input logic             a_valid_i,
  input logic             a_ready_o,
  input logic             a_last_i,
  input logic             b_valid_i,
  input logic             b_ready_o,
  input logic             b_last_i,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [ACC_W-1:0] res_data_o,
  input logic             err_o
);
  logic fire;
  assign fire = a_valid_i & b_valid_i & a_ready_o;

  AST_READY_PAIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_ready_o == b_ready_o); // R1
  AST_STALL_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |-> !a_ready_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o))); // R2
  AST_MUL_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && mode_i) |=> res_valid_o); // R3
  AST_NO_MIDVEC_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mode_i && !a_last_i && !b_last_i) |=> !res_valid_o); // R4
  AST_EOV_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mode_i && (a_last_i || b_last_i)) |=> res_valid_o); // R4
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (a_last_i != b_last_i)) |=> err_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R7
endmodule

bind vmac_node vmac_node_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/tb_vmac_node.sv
`timescale 1ns/1ps
module tb_vmac_node;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        a_valid_i = 1'b0, b_valid_i = 1'b0;
  logic        a_last_i = 1'b0, b_last_i = 1'b0;
  logic [15:0] a_data_i = '0, b_data_i = '0;
  logic        a_ready_o, b_ready_o, res_valid_o, err_o;
  logic        res_ready_i = 1'b1;
  logic [39:0] res_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  vmac_node dut (.*);

  typedef struct packed {
    logic        mode;
    logic [15:0] a;
    logic [15:0] b;
    logic        last;
    logic        emit;
    logic [39:0] exp;
  } row_t;

  localparam int NROWS = 10;
  localparam row_t ROWS [NROWS] = '{
    '{1'b1, 16'd3,      16'd4,      1'b0, 1'b1, 40'd12},          // R3
    '{1'b1, -16'sd5,    16'd7,      1'b0, 1'b1, -40'sd35},        // R3
    '{1'b1, 16'h8000,   16'h8000,   1'b0, 1'b1, 40'd1073741824},  // R3
    '{1'b0, 16'd2,      16'd3,      1'b0, 1'b0, 40'd0},           // R4
    '{1'b0, 16'd4,      16'd5,      1'b0, 1'b0, 40'd0},           // R4
    '{1'b0, -16'sd1,    16'd6,      1'b1, 1'b1, 40'd20},          // R4
    '{1'b0, 16'd7,      -16'sd8,    1'b1, 1'b1, -40'sd56},        // R5 R6
    '{1'b0, 16'd100,    16'd100,    1'b0, 1'b0, 40'd0},           // R4
    '{1'b1, 16'd1,      16'd1,      1'b0, 1'b1, 40'd1},           // R3
    '{1'b0, 16'd2,      16'd2,      1'b1, 1'b1, 40'd4}            // R5
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    #22 rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R8 res_valid", 40'(res_valid_o), 40'd0);
    chk("R8 err", 40'(err_o), 40'd0);
    chk("R8 ready", 40'({a_ready_o, b_ready_o}), 40'd3);

    // table walk, consumer always ready
    for (int i = 0; i < NROWS; i++) begin
      mode_i = ROWS[i].mode; a_data_i = ROWS[i].a; b_data_i = ROWS[i].b;
      a_last_i = ROWS[i].last; b_last_i = ROWS[i].last;
      a_valid_i = 1'b1; b_valid_i = 1'b1;
      @(negedge clk_i);
      a_valid_i = 1'b0; b_valid_i = 1'b0;
      chk($sformatf("R3/R4 row %0d valid", i), 40'(res_valid_o), 40'(ROWS[i].emit));
      if (ROWS[i].emit) chk($sformatf("R3/R4/R5 row %0d data", i), res_data_o, ROWS[i].exp);
      @(negedge clk_i);
    end

    // R1: lone operand is never consumed
    mode_i = 1'b1; a_data_i = 16'd9; a_valid_i = 1'b1; a_last_i = 1'b0; b_last_i = 1'b0;
    repeat (2) begin
      @(negedge clk_i);
      chk("R1 lone A no output", 40'(res_valid_o), 40'd0);
      chk("R1 ready paired", 40'({a_ready_o, b_ready_o}), 40'd3);
    end
    b_data_i = 16'd11; b_valid_i = 1'b1;
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0;
    chk("R1 pair fires", res_data_o, 40'd99);
    @(negedge clk_i);

    // R2: backpressure
    res_ready_i = 1'b0;
    a_data_i = 16'd3; b_data_i = 16'd3; a_valid_i = 1'b1; b_valid_i = 1'b1;
    @(negedge clk_i);
    a_data_i = 16'd2; b_data_i = 16'd2;
    repeat (3) begin
      chk("R2 held valid", 40'(res_valid_o), 40'd1);
      chk("R2 held data", res_data_o, 40'd9);
      chk("R2 ready low", 40'({a_ready_o, b_ready_o}), 40'd0);
      @(negedge clk_i);
    end
    res_ready_i = 1'b1;
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0;
    chk("R2 next result", res_data_o, 40'd4);
    @(negedge clk_i);
    chk("R2 drained", 40'(res_valid_o), 40'd0);

    // R9: 512 pairs of (-2^15)^2 sum to 2^39, wraps to -2^39
    mode_i = 1'b0; a_data_i = 16'h8000; b_data_i = 16'h8000;
    a_valid_i = 1'b1; b_valid_i = 1'b1;
    for (int k = 0; k < 512; k++) begin
      a_last_i = (k == 511); b_last_i = (k == 511);
      @(negedge clk_i);
    end
    a_valid_i = 1'b0; b_valid_i = 1'b0; a_last_i = 1'b0; b_last_i = 1'b0;
    chk("R9 wrap", res_data_o, 40'h80_0000_0000);
    @(negedge clk_i);

    // R7: flag mismatch
    chk("R7 err clear before", 40'(err_o), 40'd0);
    a_data_i = 16'd3; b_data_i = 16'd3; a_last_i = 1'b1; b_last_i = 1'b0;
    a_valid_i = 1'b1; b_valid_i = 1'b1;
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0; a_last_i = 1'b0;
    chk("R7 err set", 40'(err_o), 40'd1);
    chk("R7 mismatch ends vector", res_data_o, 40'd9);
    mode_i = 1'b1; a_valid_i = 1'b1; b_valid_i = 1'b1;
    @(negedge clk_i);
    a_valid_i = 1'b0; b_valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R7 err sticky", 40'(err_o), 40'd1);

    summary();
  end
endmodule